// File: doc/BRIEF.md
# Bus Watchpoint Trigger Unit

This block watches a processor bus and raises a trigger when a programmed transfer has been seen a given number of times. Two independent watchpoints each hold a reference address, a reference transfer type, a don't-care mask for each, and a 4-bit occurrence threshold. A watchpoint counts a transfer only when the bus valid qualifier is high and every unmasked address and type bit matches.

A source select chooses which watchpoint may fire the trigger: watchpoint 0, watchpoint 1, either one, or none. When the selected source's countdown is used up, the unit emits a one-cycle trigger pulse and freezes the address, transfer type and data of the firing transfer into snapshot outputs, along with the watchpoints that hit on that transfer. The unit then stays disarmed, ignoring the bus and keeping the snapshot, until software pulses the re-arm input.

Top module: `bus_watch_trigger`

## Requirements
- R1: While reset is asserted and right after it, trig is 0, armed is 0, and snap_addr, snap_type, snap_data and snap_hit are all 0.
- R2: A watchpoint matches a transfer only when bus_valid is 1, every address bit whose mask bit is 0 equals the reference, and every type bit whose type-mask bit is 0 equals the reference type. A mask bit of 1 means don't care.
- R3: A watchpoint programmed with count N fires on its (N+1)-th matching transfer while armed; N = 0 fires on the first match. Every watchpoint counts while armed, whether it is selected or not.
- R4: trig is high for exactly one cycle, in the cycle after the clock edge that sampled the firing transfer.
- R5: On firing, snap_addr, snap_type and snap_data take the values of the firing transfer, and snap_hit takes {hit1, hit0}: bit i is 1 when watchpoint i had an expired count and matched on that transfer.
- R6: Firing clears armed. While armed is 0, matches produce no trigger, do not change any counter, and leave the snapshot unchanged.
- R7: A re-arm pulse sets armed and reloads both counters from their programmed counts. Re-arm takes priority over a match in the same cycle, which then neither fires nor counts.
- R8: sel = 0 takes watchpoint 0 as the trigger source, 1 takes watchpoint 1, 2 takes either one, and 3 disables triggering.
- R9: A configuration write (cfg_we, with cfg_idx choosing the watchpoint) replaces that watchpoint's references, masks and count and reloads its counter. It applies to transfers from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 1 | Watchpoint being written |
| cfg_addr | input | 32 | Reference address |
| cfg_amask | input | 32 | Address don't-care mask |
| cfg_type | input | 4 | Reference transfer type |
| cfg_tmask | input | 4 | Type don't-care mask |
| cfg_count | input | 4 | Occurrence threshold |
| sel | input | 2 | Trigger source select |
| rearm | input | 1 | Re-arm pulse |
| bus_valid | input | 1 | Valid-transfer qualifier |
| bus_addr | input | 32 | Bus address |
| bus_type | input | 4 | Bus transfer type / control |
| bus_data | input | 64 | Bus data |
| trig | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | Unit is armed |
| snap_addr | output | 32 | Captured address |
| snap_type | output | 4 | Captured transfer type |
| snap_data | output | 64 | Captured data |
| snap_hit | output | 2 | Watchpoints that hit on the captured transfer |

## Verification
The bench tests the off-by-one in the countdown with both a zero count and a nonzero count. A design that fires on the N-th match instead of the (N+1)-th would trigger one transfer early. It sends transfers that match with valid low, and transfers that miss by a single unmasked bit. A broken qualifier or mask would count these transfers and trigger too early. It also sends matches after a trigger, where a design that does not disarm would pulse again or overwrite the snapshot. Finally it drives a re-arm in the same cycle as a match, which would trigger at once if the priority were wrong, and lets both watchpoints hit together under the "either" source to check the hit bits.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [1:0] {
    SRC_WP0  = 2'd0,
    SRC_WP1  = 2'd1,
    SRC_ANY  = 2'd2,
    SRC_NONE = 2'd3
  } src_sel_e;
endpackage

// File: rtl/bwt_watchpoint.sv
module bwt_watchpoint #(
  parameter int AW = 32,
  parameter int TW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_amask,
  input  logic [TW-1:0] ld_type,
  input  logic [TW-1:0] ld_tmask,
  input  logic [CW-1:0] ld_count,
  input  logic          reload,
  input  logic          armed,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_type,
  output logic          hit
);
  logic [AW-1:0] ref_addr_q, amask_q;
  logic [TW-1:0] ref_type_q, tmask_q;
  logic [CW-1:0] thresh_q, cnt_q, cnt_d;
  logic          match, dec;

  assign match = bus_valid
               && (((bus_addr ^ ref_addr_q) & ~amask_q) == '0)
               && (((bus_type ^ ref_type_q) & ~tmask_q) == '0);
  assign hit = armed && match && (cnt_q == '0);
  assign dec = armed && match && (cnt_q != '0) && !load && !reload;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = ld_count;
    else if (reload) cnt_d = thresh_q;
    else if (dec)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr_q <= '0;
      amask_q    <= '0;
      ref_type_q <= '0;
      tmask_q    <= '0;
      thresh_q   <= '0;
    end else if (load) begin
      ref_addr_q <= ld_addr;
      amask_q    <= ld_amask;
      ref_type_q <= ld_type;
      tmask_q    <= ld_tmask;
      thresh_q   <= ld_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec) |-> (cnt_q == $past(cnt_q) - CW'(1))); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (cnt_q == $past(ld_count))); // R9
endmodule

// File: rtl/bwt_snapshot.sv
module bwt_snapshot #(
  parameter int AW = 32,
  parameter int TW = 4,
  parameter int DW = 64,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] in_addr,
  input  logic [TW-1:0] in_type,
  input  logic [DW-1:0] in_data,
  input  logic [NW-1:0] in_hit,
  output logic [AW-1:0] snap_addr,
  output logic [TW-1:0] snap_type,
  output logic [DW-1:0] snap_data,
  output logic [NW-1:0] snap_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_addr <= '0;
      snap_type <= '0;
      snap_data <= '0;
      snap_hit  <= '0;
    end else if (cap) begin
      snap_addr <= in_addr;
      snap_type <= in_type;
      snap_data <= in_data;
      snap_hit  <= in_hit;
    end
  end
endmodule

// File: rtl/bus_watch_trigger.sv
module bus_watch_trigger #(
  parameter int AW = 32,
  parameter int TW = 4,
  parameter int DW = 64,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_amask,
  input  logic [TW-1:0] cfg_type,
  input  logic [TW-1:0] cfg_tmask,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    sel,
  input  logic          rearm,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_type,
  input  logic [DW-1:0] bus_data,
  output logic          trig,
  output logic          armed,
  output logic [AW-1:0] snap_addr,
  output logic [TW-1:0] snap_type,
  output logic [DW-1:0] snap_data,
  output logic [1:0]    snap_hit
);
  import bwt_pkg::*;
  localparam int NWP = 2;

  logic [NWP-1:0] hits;
  logic           src_hit, fire, armed_d;

  for (genvar i = 0; i < NWP; i++) begin : g_wp
    bwt_watchpoint #(.AW(AW), .TW(TW), .CW(CW)) u_wp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we && (cfg_idx == 1'(i))),
      .ld_addr  (cfg_addr),
      .ld_amask (cfg_amask),
      .ld_type  (cfg_type),
      .ld_tmask (cfg_tmask),
      .ld_count (cfg_count),
      .reload   (rearm),
      .armed    (armed),
      .bus_valid(bus_valid),
      .bus_addr (bus_addr),
      .bus_type (bus_type),
      .hit      (hits[i])
    );
  end

  always_comb begin
    case (src_sel_e'(sel))
      SRC_WP0: src_hit = hits[0];
      SRC_WP1: src_hit = hits[1];
      SRC_ANY: src_hit = |hits;
      default: src_hit = 1'b0;
    endcase
  end

  assign fire = armed && !rearm && src_hit;

  always_comb begin
    armed_d = armed;
    if (rearm)     armed_d = 1'b1;
    else if (fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      armed <= armed_d;
      trig  <= fire;
    end
  end

  bwt_snapshot #(.AW(AW), .TW(TW), .DW(DW), .NW(NWP)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (fire),
    .in_addr  (bus_addr),
    .in_type  (bus_type),
    .in_data  (bus_data),
    .in_hit   (hits),
    .snap_addr(snap_addr),
    .snap_type(snap_type),
    .snap_data(snap_data),
    .snap_hit (snap_hit)
  );

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R4
  AST_TRIG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed)); // R4
  AST_TRIG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |-> ($stable(snap_addr) && $stable(snap_type) && $stable(snap_data))); // R5
  AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) |-> (armed && !trig)); // R7
  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == 2'd3) |-> !trig); // R8
  AST_HIT_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (snap_hit != 2'b00)); // R5
endmodule

// File: tb/bus_watch_trigger_test.sv
`timescale 1ns/1ps
module bus_watch_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_idx;
  logic [31:0] cfg_addr, cfg_amask;
  logic [3:0]  cfg_type, cfg_tmask, cfg_count;
  logic [1:0]  sel;
  logic        rearm, bus_valid;
  logic [31:0] bus_addr;
  logic [3:0]  bus_type;
  logic [63:0] bus_data;
  logic        trig, armed;
  logic [31:0] snap_addr;
  logic [3:0]  snap_type;
  logic [63:0] snap_data;
  logic [1:0]  snap_hit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_watch_trigger uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_amask(cfg_amask), .cfg_type(cfg_type),
    .cfg_tmask(cfg_tmask), .cfg_count(cfg_count), .sel(sel), .rearm(rearm),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_type(bus_type),
    .bus_data(bus_data), .trig(trig), .armed(armed), .snap_addr(snap_addr),
    .snap_type(snap_type), .snap_data(snap_data), .snap_hit(snap_hit)
  );

  // behavioural reference model
  logic [31:0] m_ref[2], m_am[2];
  logic [3:0]  m_rt[2], m_tm[2];
  int          m_thr[2], m_cnt[2];
  bit          m_armed, m_trig;
  logic [31:0] m_sa;
  logic [3:0]  m_st;
  logic [63:0] m_sd;
  logic [1:0]  m_sh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_ref[i] = 0; m_am[i] = 0; m_rt[i] = 0; m_tm[i] = 0;
        m_thr[i] = 0; m_cnt[i] = 0;
      end
      m_armed = 0; m_trig = 0; m_sa = 0; m_st = 0; m_sd = 0; m_sh = 0;
    end else begin
      bit mt[2];
      bit h[2];
      bit f;
      for (int i = 0; i < 2; i++) begin
        mt[i] = bus_valid && (((bus_addr ^ m_ref[i]) & ~m_am[i]) == 0)
                && (((bus_type ^ m_rt[i]) & ~m_tm[i]) == 0);
        h[i] = m_armed && mt[i] && (m_cnt[i] == 0);
      end
      case (sel)
        2'd0: f = h[0];
        2'd1: f = h[1];
        2'd2: f = h[0] || h[1];
        default: f = 0;
      endcase
      f = f && m_armed && !rearm;
      if (f) begin
        m_sa = bus_addr; m_st = bus_type; m_sd = bus_data; m_sh = {h[1], h[0]};
      end
      for (int i = 0; i < 2; i++) begin
        if (cfg_we && cfg_idx == i[0]) begin
          m_ref[i] = cfg_addr; m_am[i] = cfg_amask; m_rt[i] = cfg_type;
          m_tm[i] = cfg_tmask; m_thr[i] = cfg_count; m_cnt[i] = cfg_count;
        end else if (rearm) m_cnt[i] = m_thr[i];
        else if (m_armed && mt[i] && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
      end
      m_trig = f;
      if (rearm) m_armed = 1; else if (f) m_armed = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R4 model trig", {63'd0, trig}, {63'd0, m_trig});
      chk("R6 model armed", {63'd0, armed}, {63'd0, m_armed});
      chk("R5 model snap_addr", {32'd0, snap_addr}, {32'd0, m_sa});
      chk("R5 model snap_data", snap_data, m_sd);
      chk("R5 model snap_type/hit", {58'd0, snap_hit, snap_type}, {58'd0, m_sh, m_st});
    end
  end

  task automatic cyc(input bit v, input logic [31:0] a, input logic [3:0] t,
                     input logic [63:0] d, input bit ra = 0);
    bus_valid = v; bus_addr = a; bus_type = t; bus_data = d; rearm = ra;
    @(negedge clk);
    bus_valid = 0; rearm = 0;
  endtask

  task automatic prog(input bit idx, input logic [31:0] a, input logic [31:0] am,
                      input logic [3:0] t, input logic [3:0] tm, input logic [3:0] c);
    cfg_we = 1; cfg_idx = idx; cfg_addr = a; cfg_amask = am;
    cfg_type = t; cfg_tmask = tm; cfg_count = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_rearm();
    rearm = 1;
    @(negedge clk);
    rearm = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_addr = 0; cfg_amask = 0;
    cfg_type = 0; cfg_tmask = 0; cfg_count = 0; sel = 0; rearm = 0;
    bus_valid = 0; bus_addr = 0; bus_type = 0; bus_data = 0;
    repeat (3) @(negedge clk);
    chk("R1 trig", {63'd0, trig}, 64'd0);
    chk("R1 armed", {63'd0, armed}, 64'd0);
    chk("R1 snapshot", {snap_addr, snap_type, snap_hit, 26'd0} | snap_data, 64'd0);
    rst_n = 1;
    @(negedge clk);

    prog(0, 32'h1000_0000, 32'h0000_00FF, 4'h1, 4'h0, 4'd2);
    prog(1, 32'h2000_0040, 32'h0, 4'h0, 4'hF, 4'd0);
    sel = 2'd0;
    do_rearm();
    chk("R7 armed after rearm", {63'd0, armed}, 64'd1);
    cyc(1, 32'h1000_0012, 4'h1, 64'h1);
    chk("R3 first of three", {63'd0, trig}, 64'd0);
    cyc(0, 32'h1000_0012, 4'h1, 64'h2);
    cyc(1, 32'h1000_0112, 4'h1, 64'h3);
    cyc(1, 32'h1000_00FF, 4'h2, 64'h4);
    chk("R2 unqualified or mismatched", {63'd0, trig}, 64'd0);
    cyc(1, 32'h1000_0034, 4'h1, 64'h5);
    chk("R2 second counted match", {63'd0, trig}, 64'd0);
    cyc(1, 32'h1000_0056, 4'h1, 64'hDEAD_BEEF_0123_4567);
    chk("R3 fires on third match", {63'd0, trig}, 64'd1);
    chk("R5 snap addr", {32'd0, snap_addr}, 64'h1000_0056);
    chk("R5 snap data", snap_data, 64'hDEAD_BEEF_0123_4567);
    chk("R5 snap hit", {62'd0, snap_hit}, 64'd1);
    chk("R6 disarmed", {63'd0, armed}, 64'd0);
    cyc(0, 0, 0, 0);
    chk("R4 single pulse", {63'd0, trig}, 64'd0);
    cyc(1, 32'h1000_0078, 4'h1, 64'h9);
    chk("R6 ignored while disarmed", {63'd0, trig}, 64'd0);
    chk("R6 snapshot kept", {32'd0, snap_addr}, 64'h1000_0056);

    sel = 2'd1;
    do_rearm();
    cyc(1, 32'h1000_0001, 4'h1, 64'h7);
    chk("R8 wp0 not selected", {63'd0, trig}, 64'd0);
    cyc(1, 32'h2000_0040, 4'h7, 64'h8);
    chk("R8 wp1 fires, R3 count zero", {63'd0, trig}, 64'd1);
    chk("R8 snap type", {60'd0, snap_type}, 64'h7);

    sel = 2'd2;
    do_rearm();
    cyc(1, 32'h2000_0040, 4'h3, 64'hA);
    chk("R8 either source", {63'd0, trig}, 64'd1);
    chk("R8 hit bits wp1", {62'd0, snap_hit}, 64'd2);

    prog(0, 32'h0, 32'hFFFF_FFFF, 4'h1, 4'h0, 4'd0);
    do_rearm();
    cyc(1, 32'h2000_0040, 4'h1, 64'hB);
    chk("R9 reprogram applied, R8 both hit", {62'd0, snap_hit}, 64'd3);

    sel = 2'd3;
    do_rearm();
    cyc(1, 32'h2000_0040, 4'h1, 64'hC);
    chk("R8 none selected", {63'd0, trig}, 64'd0);
    chk("R8 still armed", {63'd0, armed}, 64'd1);

    sel = 2'd0;
    cyc(1, 32'h2000_0040, 4'h1, 64'hD, 1);
    chk("R7 rearm beats match", {63'd0, trig}, 64'd0);
    prog(0, 32'h3000_0000, 32'h0, 4'h2, 4'h0, 4'd1);
    do_rearm();
    cyc(1, 32'h3000_0000, 4'h2, 64'hE);
    do_rearm();
    cyc(1, 32'h3000_0000, 4'h2, 64'hF);
    chk("R7 reload restores count", {63'd0, trig}, 64'd0);
    cyc(1, 32'h3000_0000, 4'h2, 64'h10);
    chk("R3 count one fires on second", {63'd0, trig}, 64'd1);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [31:0] a;
      r = $urandom_range(0, 99);
      if (r < 2) begin
        prog($urandom_range(0, 1), 32'h3000_0000 | ($urandom & 32'h3), $urandom & 32'h1,
             4'($urandom), 4'($urandom & 4'h3), 4'($urandom_range(0, 3)));
      end else begin
        if (r < 4) sel = 2'($urandom);
        case ($urandom_range(0, 2))
          0: a = 32'h3000_0000 | ($urandom & 32'h3);
          1: a = 32'h2000_0040;
          default: a = $urandom;
        endcase
        cyc($urandom_range(0, 3) != 0, a, 4'($urandom), {$urandom, $urandom},
            $urandom_range(0, 24) == 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule